// File: doc/BRIEF.md
# Pulse interval capture timer

This block is one timer channel that measures the time between successive valid edges on an external input pin. A start control clears a 16-bit up counter and arms the channel. The counter then advances by one on each cycle where the count-clock enable is high. Each valid edge of the synchronized pin, or a software trigger, latches the running count into a capture register, restarts the counter from zero and raises a one-cycle interrupt. The same event refreshes an overflow flag that tells whether the counter wrapped during the period just measured.

Software rebuilds the interval from the captured count and the flag. In count-clock periods the interval is 2^W × flag + capture + 1. A stop control freezes the channel. The last result stays readable while the channel is stopped. Edge polarity is selectable: rising, falling or both. The pin passes through a two-flop synchronizer, so a pin change is resolved to the operating clock.

Top module: `pulse_interval_timer`

## Requirements
- R1: A start pulse (start_i high, stop_i low) clears the counter to 0 and runs the channel. The counter then rises by one on each clock where cnt_en_i is high and holds where it is low. A start in the same cycle as a trigger wins, and no capture happens in that cycle.
- R2: A pin change that forms a valid edge is captured on the third rising clock edge after it is applied: two synchronizer stages, then the capture register. The count at that edge goes to cap_data_o, the counter restarts from 0, and irq_o is high for exactly the following cycle.
- R3: The overflow flag ovf_o changes only at a capture. It is then set to 1 if the counter wrapped from all-ones to 0 since the previous capture or start, and to 0 otherwise.
- R4: A wrap on the count-clock edge just before the capture edge (captured value 0) counts as an overflow of the period that ends. The wrap record is cleared at every capture, so the next period starts without overflow.
- R5: Two or more wraps in one period give ovf_o = 1, the same as a single wrap. The captured value is the interval minus one, modulo 2^W.
- R6: While the channel runs, sw_trig_i high at a clock edge captures at that same edge, exactly like a valid pin edge.
- R7: edge_sel_i chooses the valid edge: 2'b00 rising only, 2'b01 falling only, 2'b10 or 2'b11 both edges. Edges of the other polarity cause no capture.
- R8: A stop pulse (stop_i high; it wins over start_i) halts counting. While stopped, pin edges and software triggers cause no interrupt, and cap_data_o and ovf_o keep their values.
- R9: Reset (rst_ni low) clears the counter, cap_data_o, ovf_o and the wrap record, drives irq_o low and leaves the channel stopped.
- R10: With cnt_en_i held high and fewer than two wraps, the number of clocks between two captured pin changes equals 2^W × ovf_o + cap_data_o + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Operating clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-clock enable; the counter advances only when high |
| pin_i | input | 1 | External input whose edge interval is measured |
| edge_sel_i | input | 2 | Valid edge: 00 rising, 01 falling, 1x both |
| start_i | input | 1 | Clears the counter and runs the channel |
| stop_i | input | 1 | Halts the channel; wins over start_i |
| sw_trig_i | input | 1 | Software capture trigger |
| cap_data_o | output | CNT_W | Count latched at the last capture |
| ovf_o | output | 1 | Counter wrapped during the last measured period |
| irq_o | output | 1 | One-cycle pulse after each capture |

## Verification
A pin change driven on a falling clock edge shows up in cap_data_o, ovf_o and irq_o at the falling edge that follows the third rising edge. The bench samples exactly there. It also checks that irq_o is low one sample earlier and one sample later. A software trigger and a start are sampled at the next rising edge, so their results are read one falling edge later. The expected counts follow from the number of clocks between stimuli: the captured value is that distance minus one for pin changes. For a software trigger it is the number of enabled counts since the last restart. Windows in which no capture may occur sample irq_o at every falling edge.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/pit_edge_detect.sv
module pit_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       edge_o
);
  import pit_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   rise, fall;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    unique case (edge_sel_e'(edge_sel_i))
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      default:   edge_o = rise | fall;
    endcase
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_pend_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      wrap_pend_o <= 1'b0;
    end else if (clear_i) begin
      cnt_o       <= '0;
      wrap_pend_o <= 1'b0;
    end else if (inc_i) begin
      cnt_o <= cnt_o + 1'b1;
      if (cnt_o == CntMax) wrap_pend_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pit_capture.sv
module pit_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_pend_i,
  output logic [CNT_W-1:0] cap_data_o,
  output logic             ovf_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_data_o <= '0;
      ovf_o      <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= cap_i;
      if (cap_i) begin
        cap_data_o <= cnt_i;
        ovf_o      <= wrap_pend_i;
      end
    end
  end
endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             pin_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sw_trig_i,
  output logic [CNT_W-1:0] cap_data_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic             run_q;
  logic             edge_hit;
  logic             start_evt, cap_evt, inc;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_pend_q;

  // stop wins over start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (stop_i)  run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
  end

  assign start_evt = start_i & ~stop_i;
  assign cap_evt   = run_q & ~stop_i & ~start_i & (edge_hit | sw_trig_i);
  assign inc       = run_q & ~stop_i & cnt_en_i;

  pit_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .edge_sel_i (edge_sel_i),
    .edge_o     (edge_hit)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_evt | cap_evt),
    .inc_i       (inc),
    .cnt_o       (cnt_q),
    .wrap_pend_o (wrap_pend_q)
  );

  pit_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap_evt),
    .cnt_i       (cnt_q),
    .wrap_pend_i (wrap_pend_q),
    .cap_data_o  (cap_data_o),
    .ovf_o       (ovf_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             run_q,
  input logic             cap_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wrap_pend_q,
  input logic [CNT_W-1:0] cap_data_o,
  input logic             ovf_o,
  input logic             irq_o
);
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (cnt_q == '0)); // R1

  AST_CAP_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cnt_q == '0)); // R2

  AST_CAP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> $stable(cap_data_o)); // R2

  AST_OVF_ONLY_AT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> $stable(ovf_o)); // R3

  AST_WRAP_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !stop_i && !start_i && !cap_evt && cnt_en_i && cnt_q == '1)
    |=> wrap_pend_q); // R4

  AST_OVF_FROM_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_o == $past(wrap_pend_q))); // R4

  AST_STOPPED_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !irq_o); // R8

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> $stable(cnt_q)); // R8
endmodule

bind pulse_interval_timer pit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_en_i    (cnt_en_i),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .run_q       (run_q),
  .cap_evt     (cap_evt),
  .cnt_q       (cnt_q),
  .wrap_pend_q (wrap_pend_q),
  .cap_data_o  (cap_data_o),
  .ovf_o       (ovf_o),
  .irq_o       (irq_o)
);

// File: tb/pulse_interval_timer_tb.sv
module pulse_interval_timer_tb;
  localparam int W   = 8;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b1;
  logic         pin = 1'b0;
  logic [1:0]   esel = 2'b10;
  logic         start = 1'b0;
  logic         stop = 1'b0;
  logic         sw = 1'b0;
  logic [W-1:0] cap;
  logic         ovf;
  logic         irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cap;

  always #10 clk = ~clk;

  pulse_interval_timer #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .pin_i(pin),
    .edge_sel_i(esel), .start_i(start), .stop_i(stop), .sw_trig_i(sw),
    .cap_data_o(cap), .ovf_o(ovf), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  // four samples after a pin change; capture due at the third
  task automatic expect_capture(input string req, input int ecap, input int eovf);
    @(negedge clk);
    @(negedge clk);
    check({req, " irq early"}, int'(irq), 0);
    @(negedge clk);
    check({req, " irq"}, int'(irq), 1);
    check({req, " cap"}, int'(cap), ecap);
    check({req, " ovf"}, int'(ovf), eovf);
    @(negedge clk);
    check({req, " irq one cycle"}, int'(irq), 0);
    last_cap = ecap;
  endtask

  task automatic no_irq_window(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    check(req, seen, 0);
  endtask

  task automatic sw_capture(input string req, input int ecap, input int eovf);
    sw = 1'b1; @(negedge clk); sw = 1'b0;
    check({req, " irq"}, int'(irq), 1);
    check({req, " cap"}, int'(cap), ecap);
    check({req, " ovf"}, int'(ovf), eovf);
    last_cap = ecap;
  endtask

  // one interval of b clocks between pin changes, both-edge mode
  task automatic run_interval(input int b, input string req);
    int d = b - 1;
    repeat (b - 4) @(negedge clk);
    pin = ~pin;
    expect_capture(req, d % MOD, (d >= MOD) ? 1 : 0);
    if (d < 2 * MOD)
      check("R10 rebuild", MOD * int'(ovf) + int'(cap) + 1, b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 cap", int'(cap), 0);
    check("R9 ovf", int'(ovf), 0);
    check("R9 irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pin = 1'b1;
    no_irq_window("R9 stopped after reset", 6);

    // R2 first capture after start: distance a from start gives a+1
    pulse_start();
    repeat (9) @(negedge clk);
    pin = ~pin;
    expect_capture("R2 first", 11, 0);

    // R10 / R3 sweep of intervals
    for (int b = 4; b <= 600; b += 3) run_interval(b, "R10 sweep");
    run_interval(MOD, "R3 no wrap at full count");
    run_interval(MOD + 1, "R4 wrap just before capture");
    run_interval(10, "R4 next period clear");
    run_interval(2 * MOD + 1, "R5 two wraps");
    run_interval(3 * MOD + 7, "R5 three wraps");
    run_interval(20, "R3 flag cleared");

    // R6 software trigger: counter is 1 here, k more clocks -> k+1
    repeat (20) @(negedge clk);
    sw_capture("R6 sw trigger", 21, 0);

    // R8 stop: triggers ignored, results held
    pulse_stop();
    pin = ~pin;
    repeat (2) @(negedge clk);
    sw = 1'b1; @(negedge clk); sw = 1'b0;
    no_irq_window("R8 no irq while stopped", 6);
    check("R8 cap held", int'(cap), last_cap);
    check("R8 ovf held", int'(ovf), 0);

    // R7 rising only
    pin = 1'b0;
    repeat (4) @(negedge clk);
    esel = 2'b00;
    pulse_start();
    repeat (9) @(negedge clk);
    pin = 1'b1;
    expect_capture("R7 rise", 11, 0);
    repeat (6) @(negedge clk);
    pin = 1'b0;
    no_irq_window("R7 fall ignored in rise mode", 4);
    repeat (16) @(negedge clk);
    pin = 1'b1;
    expect_capture("R7 rise after ignored fall", 29, 0);

    // R7 falling only
    esel = 2'b01;
    repeat (6) @(negedge clk);
    pin = 1'b0;
    expect_capture("R7 fall", 9, 0);
    repeat (6) @(negedge clk);
    pin = 1'b1;
    no_irq_window("R7 rise ignored in fall mode", 4);

    // R1 count enable gates counting
    pulse_stop();
    cnt_en = 1'b0;
    pulse_start();
    repeat (20) @(negedge clk);
    sw_capture("R1 enable low holds count", 0, 0);
    cnt_en = 1'b1;
    repeat (13) @(negedge clk);
    sw_capture("R1 counts when enabled", 13, 0);

    // R1 restart mid-period, then start vs trigger in one cycle
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (7) @(negedge clk);
    sw_capture("R1 restart clears count", 7, 0);
    start = 1'b1; sw = 1'b1;
    @(negedge clk);
    start = 1'b0; sw = 1'b0;
    check("R1 start beats trigger", int'(irq), 0);
    check("R1 start beats trigger cap", int'(cap), 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule